// File: doc/BRIEF.md
# MII Receive Header Stripper

This block sits on the 4-bit MII receive path, right after the pins. At the start of each frame it examines the nibble stream, looking for the start-of-frame delimiter and for signs of a broken preamble. When the delimiter is found it removes the header and pairs the following nibbles into bytes, low nibble first. The bytes go out on a byte-valid interface that marks the first and last byte of the frame. A frame whose header is malformed is dropped whole, and nothing of it reaches the output.

The preamble nibble is 0x5 and the delimiter byte 0xD5 arrives as nibble 0x5 then nibble 0xD. Within a nibble, bit 0 is the first bit on the wire. The header may be as short as the delimiter byte alone. Status pulses report an accepted header, a dropped frame and an odd trailing nibble. Address filtering, CRC checking and buffering are handled by later stages.

Top module: `mii_rx_sfd_detect`

## Requirements
- R1: After reset, out_valid, out_sof, out_eof, hdr_ok, frame_drop and dribble_err are all 0.
- R2: While hunting, a nibble 0xD whose preceding nibble in the same frame was 0x5 is taken as the delimiter. Any number of preceding 0x5 nibbles is accepted, including none beyond the delimiter's own low nibble. hdr_ok pulses for one cycle, visible one clock after the 0xD nibble is sampled.
- R3: Header nibbles are never forwarded. After the delimiter, each nibble pair is output as one byte {second nibble, first nibble}, in arrival order.
- R4: out_sof is high with the first output byte of a frame. out_eof is high only with the last output byte, and that byte appears one clock after rx_dv is sampled low.
- R5: Before the delimiter, two consecutive zero bits cause the frame to be dropped. Bits are taken bit 0 first inside each nibble and across nibble boundaries. On a drop, frame_drop pulses once and nothing of the frame is output.
- R6: If rx_dv deasserts while still hunting for the delimiter, with no zero pair seen, frame_drop pulses once and nothing is output.
- R7: A dropped frame is discarded until rx_dv deasserts, even if it later contains a valid header. The next frame is then examined afresh.
- R8: If an odd nibble remains when rx_dv deasserts after the delimiter, dribble_err pulses and that nibble is not output. out_eof still marks the last whole byte.
- R9: Before the delimiter, nibbles other than 0x5 that contain no zero pair are skipped without dropping the frame. This includes 0xD when no 0x5 precedes it.
- R10: A frame that ends right after the delimiter gives hdr_ok, no output byte and no frame_drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_dv | input | 1 | Receive data valid |
| rx_nib | input | 4 | Receive nibble, bit 0 first on the wire |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Output byte |
| out_sof | output | 1 | First byte of frame |
| out_eof | output | 1 | Last byte of frame |
| hdr_ok | output | 1 | Delimiter found (pulse) |
| frame_drop | output | 1 | Frame dropped (pulse) |
| dribble_err | output | 1 | Odd trailing nibble (pulse) |

## Verification
The bench varies the preamble length down to the delimiter alone. A design that insisted on a full preamble would reject that shortest frame. It also places a zero pair that spans a nibble boundary (0x5 followed by 0xA), which a design checking only inside nibbles would accept. Further cases are a dropped frame that carries a valid header later on, which an early rearm would forward, and an odd trailing nibble, which a careless design would emit as a half-filled byte or use to move the end marker. A header-only frame and frames with stray non-zero-pair nibbles check that accept, drop and end-marker timing stay separate.

// File: rtl/mii_rx_sfd_detect.sv
module mii_rx_sfd_detect #(
  parameter logic [3:0] PRE_NIB = 4'h5,
  parameter logic [3:0] SFD_HI  = 4'hD
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_dv,
  input  logic [3:0] rx_nib,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       out_sof,
  output logic       out_eof,
  output logic       hdr_ok,
  output logic       frame_drop,
  output logic       dribble_err
);
  typedef enum logic [1:0] {HUNT, PAY, DISC} st_t;
  st_t        st;
  logic       dv_q, half_q, pend_v, first_q;
  logic [3:0] prev_q, lo_q;
  logic [7:0] pend_q;

  wire zpair = (~prev_q[3] & ~rx_nib[0]) | (~rx_nib[0] & ~rx_nib[1]) |
               (~rx_nib[1] & ~rx_nib[2]) | (~rx_nib[2] & ~rx_nib[3]);
  wire sfd_hit = (prev_q == PRE_NIB) && (rx_nib == SFD_HI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= HUNT; dv_q <= 1'b0; half_q <= 1'b0; pend_v <= 1'b0; first_q <= 1'b0;
      prev_q <= 4'hF; lo_q <= '0; pend_q <= '0;
      out_valid <= 1'b0; out_data <= '0; out_sof <= 1'b0; out_eof <= 1'b0;
      hdr_ok <= 1'b0; frame_drop <= 1'b0; dribble_err <= 1'b0;
    end else begin
      out_valid <= 1'b0; out_sof <= 1'b0; out_eof <= 1'b0;
      hdr_ok <= 1'b0; frame_drop <= 1'b0; dribble_err <= 1'b0;
      dv_q <= rx_dv;
      if (!rx_dv) begin
        if (st == HUNT && dv_q) frame_drop <= 1'b1;
        if (st == PAY) begin
          if (pend_v) begin
            out_valid <= 1'b1; out_data <= pend_q; out_sof <= first_q; out_eof <= 1'b1;
          end
          dribble_err <= half_q;
        end
        st <= HUNT; prev_q <= 4'hF; half_q <= 1'b0; pend_v <= 1'b0; first_q <= 1'b0;
      end else begin
        case (st)
          HUNT: begin
            if (zpair) begin
              st <= DISC; frame_drop <= 1'b1;
            end else if (sfd_hit) begin
              st <= PAY; hdr_ok <= 1'b1; first_q <= 1'b1;
            end else begin
              prev_q <= rx_nib;
            end
          end
          PAY: begin
            if (!half_q) begin
              lo_q <= rx_nib; half_q <= 1'b1;
            end else begin
              half_q <= 1'b0; pend_q <= {rx_nib, lo_q}; pend_v <= 1'b1;
              if (pend_v) begin
                out_valid <= 1'b1; out_data <= pend_q; out_sof <= first_q; first_q <= 1'b0;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_rst_quiet_R1: assert property (@(posedge clk)
    $past(!rst_n) |-> !out_valid && !hdr_ok && !frame_drop && !dribble_err);
  assert_eof_after_dv_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid && !$past(rx_dv));
  assert_sof_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  assert_ok_xor_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hdr_ok, frame_drop}));
  assert_drop_no_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    frame_drop |-> !out_valid);
  assert_dribble_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dribble_err |-> !$past(rx_dv));
  assert_ok_needs_dv_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ok |-> $past(rx_dv) && $past(rx_nib) == SFD_HI);
endmodule

// File: tb/mii_rx_sfd_detect_bench.sv
module mii_rx_sfd_detect_bench;
  localparam int PERIOD = 10;
  logic clk = 0, rst_n = 0, rx_dv = 0;
  logic [3:0] rx_nib = 0;
  logic out_valid, out_sof, out_eof, hdr_ok, frame_drop, dribble_err;
  logic [7:0] out_data;

  mii_rx_sfd_detect u_mii_rx_sfd_detect (.clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_nib(rx_nib),
    .out_valid(out_valid), .out_data(out_data), .out_sof(out_sof), .out_eof(out_eof),
    .hdr_ok(hdr_ok), .frame_drop(frame_drop), .dribble_err(dribble_err));

  always #(PERIOD/2) clk = ~clk;

  int vec = 0, bad = 0, cyc = 0;
  logic [3:0] nb [0:79];
  int nn, nexp, sfd_idx, sfd_cyc, fall_cyc;
  logic [7:0] exp_b [0:31];
  logic [7:0] cap [0:31];
  int ncap, sof_at, sof_cnt, eof_at, eof_cnt, eof_cyc, ok_cnt, ok_cyc, drop_cnt, drib_cnt;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (out_valid) begin
      if (ncap < 32) cap[ncap] = out_data;
      if (out_sof) begin sof_cnt++; sof_at = ncap; end
      if (out_eof) begin eof_cnt++; eof_at = ncap; eof_cyc = cyc; end
      ncap++;
    end
    if (hdr_ok) begin ok_cnt++; ok_cyc = cyc; end
    if (frame_drop) drop_cnt++;
    if (dribble_err) drib_cnt++;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    vec++;
    if (!ok) begin bad++; $display("FAIL %s actual=%0d expected=%0d", what, act, exp); end
  endtask

  task automatic clr();
    nn = 0; nexp = 0; sfd_idx = -1;
  endtask
  task automatic put(input logic [3:0] n);
    nb[nn] = n; nn++;
  endtask
  task automatic put_sfd();
    sfd_idx = nn; put(4'hD);
  endtask
  task automatic put_bytes(input int k, input int seed);
    for (int i = 0; i < k; i++) begin
      logic [7:0] b;
      b = 8'((i * 37 + seed) & 255);
      put(b[3:0]); put(b[7:4]); exp_b[nexp] = b; nexp++;
    end
  endtask

  task automatic play();
    ncap = 0; sof_cnt = 0; eof_cnt = 0; ok_cnt = 0; drop_cnt = 0; drib_cnt = 0;
    sof_at = -1; eof_at = -1; eof_cyc = -1; ok_cyc = -1;
    for (int i = 0; i < nn; i++) begin
      @(negedge clk); rx_dv = 1; rx_nib = nb[i];
      if (i == sfd_idx) sfd_cyc = cyc;
    end
    @(negedge clk); rx_dv = 0; rx_nib = 0; fall_cyc = cyc;
    repeat (4) @(negedge clk);
  endtask

  task automatic expect_good(input string tag, input int drib);
    chk(ok_cnt == 1, {tag, " hdr_ok count"}, ok_cnt, 1);
    chk(ok_cyc == sfd_cyc + 1, {tag, " hdr_ok timing"}, ok_cyc, sfd_cyc + 1);
    chk(drop_cnt == 0, {tag, " no drop"}, drop_cnt, 0);
    chk(drib_cnt == drib, {tag, " dribble R8"}, drib_cnt, drib);
    chk(ncap == nexp, {tag, " byte count R3"}, ncap, nexp);
    for (int i = 0; i < nexp && i < ncap; i++)
      chk(cap[i] == exp_b[i], {tag, " byte value R3"}, cap[i], exp_b[i]);
    if (nexp > 0) begin
      chk(sof_cnt == 1 && sof_at == 0, {tag, " sof R4"}, sof_at, 0);
      chk(eof_cnt == 1 && eof_at == nexp - 1, {tag, " eof pos R4"}, eof_at, nexp - 1);
      chk(eof_cyc == fall_cyc + 1, {tag, " eof timing R4"}, eof_cyc, fall_cyc + 1);
    end
  endtask

  task automatic expect_drop(input string tag);
    chk(drop_cnt == 1, {tag, " drop count"}, drop_cnt, 1);
    chk(ok_cnt == 0, {tag, " no hdr_ok"}, ok_cnt, 0);
    chk(ncap == 0, {tag, " no output"}, ncap, 0);
  endtask

  task automatic t_reset();
    chk(!out_valid && !out_sof && !out_eof && !hdr_ok && !frame_drop && !dribble_err,
        "R1 reset outputs", {out_valid, out_sof, out_eof, hdr_ok, frame_drop, dribble_err}, 0);
  endtask

  task automatic t_frame(input int npre, input int nbytes, input string tag);
    clr(); for (int i = 0; i < npre; i++) put(4'h5);
    put_sfd(); put_bytes(nbytes, npre * 11 + 1); play(); expect_good(tag, 0);
  endtask

  task automatic t_boundary_zero();
    clr(); put(4'h5); put(4'h5); put(4'hA); put(4'h5); put(4'hD); put_bytes(3, 9);
    play(); expect_drop("R5 boundary zero pair");
  endtask

  task automatic t_inner_zero_then_valid();
    clr(); put(4'h5); put(4'h4); for (int i = 0; i < 6; i++) put(4'h5);
    put(4'hD); put_bytes(4, 5);
    play(); expect_drop("R7 discard keeps valid header out");
    t_frame(3, 2, "R7 rearm");
  endtask

  task automatic t_no_sfd();
    clr(); for (int i = 0; i < 6; i++) put(4'h5);
    play(); expect_drop("R6 no delimiter");
  endtask

  task automatic t_noise();
    clr(); put(4'hF); put(4'hD); put(4'h7); put(4'h5); put_sfd(); put_bytes(3, 77);
    play(); expect_good("R9 skipped nibbles", 0);
  endtask

  task automatic t_dribble();
    clr(); for (int i = 0; i < 4; i++) put(4'h5);
    put_sfd(); put_bytes(3, 200); put(4'h9);
    play(); expect_good("R8 odd nibble", 1);
  endtask

  task automatic t_hdr_only();
    clr(); put(4'h5); put(4'h5); put_sfd();
    play(); expect_good("R10 header only", 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    bad++; $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_frame(15, 6, "R2 full preamble");
    t_frame(1, 5, "R2 delimiter only");
    t_frame(4, 1, "R2 short preamble one byte");
    t_boundary_zero();
    t_inner_zero_then_valid();
    t_no_sfd();
    t_noise();
    t_dribble();
    t_hdr_only();
    t_frame(7, 16, "R3 long payload");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule